// File: doc/BRIEF.md
# Two-Wire Register Target with 16-bit Word Access

This block lets an external controller on a two-wire serial bus reach a small bank of 16-bit configuration and status registers. The controller first writes an 8-bit register index, then moves whole 16-bit words, high byte first. An internal pointer steps by one register after every complete word, so a long burst covers consecutive registers without resending the index. A read reuses the index from a preceding write-addressed transfer, joined to it by a repeated START.

The bus pins are oversampled in a system clock that runs at least 16 times faster than SCL. The target only ever pulls SDA low through an output enable. Each committed word write is also shown to the surrounding logic on a one-cycle write port. A write that sets the tune-enable bit produces a one-cycle tune strobe. The status register mixes bits supplied by the host side with a seek/tune-done flag that the host sets and the tune strobe clears.

Top module: `i2c_word_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 0b0110101, so 0x6A selects a write and 0x6B a read. Any other address is NACKed, and every following byte is ignored (also NACKed) until the next START.
- R2: In a write, the byte after the address is the register index n. The bytes after that are n[15:8], n[7:0], n+1[15:8], and so on. A word is committed only when the ACK slot of its low byte ends.
- R3: The pointer advances by one after each full 16-bit word is written or read (a read word counts once its low byte's acknowledge slot ends). A read started without an index continues at the current pointer.
- R4: A read sets the index in a write transfer and then issues a repeated START with address 0x6B. The target returns n[15:8], n[7:0], n+1[15:8] and so on, MSB first, until the controller NACKs. The target changes SDA only after a falling SCL edge.
- R5: Register 0x01 always reads 0x4B54, and writes to it leave it unchanged.
- R6: A high byte followed by STOP, with no low byte, changes no register and raises no write strobe.
- R7: Registers 0x02 to 0x05 are read/write and reset to 0x0000. Every other address except 0x01 and 0x12 reads 0x0000 and ignores writes.
- R8: A committed write to 0x03 with bit 15 set gives exactly one tune_start_o pulse and clears bit 14 of register 0x12. A write with bit 15 clear gives no pulse. A tune_done_i pulse sets bit 14.
- R9: Register 0x12 reads status_i on all bits except bit 14, which holds the done flag.
- R10: After reset, SDA is released and tune_start_o and reg_wr_o are low.
- R11: Each committed word raises reg_wr_o for one cycle, with reg_addr_o holding the word's index and reg_wdata_o its 16-bit value, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 16 | Host-side status bits for register 0x12 |
| tune_done_i | input | 1 | One-cycle pulse that sets the done flag |
| reg_wr_o | output | 1 | One-cycle strobe for each committed word |
| reg_addr_o | output | 8 | Index of the committed word |
| reg_wdata_o | output | 16 | Value of the committed word |
| tune_start_o | output | 1 | One-cycle tune strobe |

## Verification
A wrong bit counter or state value makes the ACK bit misplaced or missing within one byte time (nine SCL periods). The controller sees that at once as a NACK or as a shifted data byte. A pointer that steps per byte instead of per word, or fails to step, shows up in the second word of any burst: data lands on the wrong register and comes back from the wrong register on read. A commit made too early is caught by the lone-high-byte case. There, reg_wr_o pulses and the readback changes within the same transfer.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_IDX, ST_IDX_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_prev_q, sda_prev_q;
  logic scl_now, sda_now;

  assign scl_now = scl_pipe_q[STAGES-1];
  assign sda_now = sda_pipe_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_now;
      sda_prev_q <= sda_now;
    end
  end

  assign sda_lvl  = sda_now;
  assign scl_rise = scl_now & ~scl_prev_q;
  assign scl_fall = ~scl_now & scl_prev_q;
  assign start_ev = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
  assign stop_ev  = scl_now & scl_prev_q & ~sda_prev_q & sda_now;
endmodule

// File: rtl/i2c_word_engine.sv
module i2c_word_engine
  import i2c_word_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h35,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BW  = 8;
  localparam int CW  = $clog2(BW + 1);
  localparam logic [CW-1:0] FULL = CW'(BW);

  tgt_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] sh_q, sh_d, hib_q, hib_d;
  logic [AW-1:0] ptr_q, ptr_d, wa_q;
  logic [DW-1:0] word_q, word_d, wd_q;
  logic oe_q, oe_d, rw_q, rw_d, lo_q, lo_d, hav_q, hav_d;
  logic pend_q, pend_d, mack_q, mack_d, we_q, we_d;
  logic rx_state;

  assign rx_state = (st_q == ST_ADDR) || (st_q == ST_IDX) || (st_q == ST_WR);
  assign rd_addr  = (st_q == ST_RD_ACK && lo_q) ? ptr_q + AW'(1) : ptr_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; hib_d = hib_q; ptr_d = ptr_q;
    word_d = word_q; oe_d = oe_q; rw_d = rw_q; lo_d = lo_q; hav_d = hav_q;
    pend_d = pend_q; mack_d = mack_q; we_d = 1'b0;
    if (start_ev) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0; hav_d = 1'b0; pend_d = 1'b0;
    end else if (stop_ev) begin
      st_d = ST_IDLE; oe_d = 1'b0; hav_d = 1'b0; pend_d = 1'b0;
    end else begin
      if (scl_rise && rx_state) begin
        sh_d  = {sh_q[BW-2:0], sda_lvl};
        cnt_d = cnt_q + CW'(1);
      end
      if (scl_rise && st_q == ST_RD) cnt_d = cnt_q + CW'(1);
      if (scl_rise && st_q == ST_RD_ACK) mack_d = ~sda_lvl;
      if (scl_fall) begin
        case (st_q)
          ST_ADDR: if (cnt_q == FULL) begin
            cnt_d = '0;
            if (sh_q[BW-1:1] == DEV_ADDR) begin
              oe_d = 1'b1; rw_d = sh_q[0]; st_d = ST_ADDR_ACK;
            end else begin
              st_d = ST_IDLE;
            end
          end
          ST_ADDR_ACK: begin
            cnt_d = '0;
            if (rw_q) begin
              word_d = rd_word; sh_d = rd_word[DW-1 -: BW];
              oe_d = ~rd_word[DW-1]; lo_d = 1'b0; st_d = ST_RD;
            end else begin
              oe_d = 1'b0; st_d = ST_IDX;
            end
          end
          ST_IDX: if (cnt_q == FULL) begin
            ptr_d = AW'(sh_q); oe_d = 1'b1; cnt_d = '0; st_d = ST_IDX_ACK;
          end
          ST_IDX_ACK: begin
            oe_d = 1'b0; hav_d = 1'b0; st_d = ST_WR;
          end
          ST_WR: if (cnt_q == FULL) begin
            oe_d = 1'b1; cnt_d = '0; st_d = ST_WR_ACK;
            if (hav_q) pend_d = 1'b1;
            else begin hib_d = sh_q; hav_d = 1'b1; end
          end
          ST_WR_ACK: begin
            oe_d = 1'b0; st_d = ST_WR;
            if (pend_q) begin
              we_d = 1'b1; pend_d = 1'b0; hav_d = 1'b0; ptr_d = ptr_q + AW'(1);
            end
          end
          ST_RD: if (cnt_q == FULL) begin
            oe_d = 1'b0; st_d = ST_RD_ACK;
          end else begin
            oe_d = ~sh_q[BW-2]; sh_d = {sh_q[BW-2:0], 1'b0};
          end
          ST_RD_ACK: begin
            cnt_d = '0;
            if (lo_q) ptr_d = ptr_q + AW'(1);
            if (!mack_q) begin
              st_d = ST_IDLE; oe_d = 1'b0;
            end else if (lo_q) begin
              word_d = rd_word; sh_d = rd_word[DW-1 -: BW];
              oe_d = ~rd_word[DW-1]; lo_d = 1'b0; st_d = ST_RD;
            end else begin
              sh_d = word_q[BW-1:0]; oe_d = ~word_q[BW-1]; lo_d = 1'b1; st_d = ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; hib_q <= '0; ptr_q <= '0;
      word_q <= '0; oe_q <= 1'b0; rw_q <= 1'b0; lo_q <= 1'b0; hav_q <= 1'b0;
      pend_q <= 1'b0; mack_q <= 1'b0; we_q <= 1'b0; wa_q <= '0; wd_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; hib_q <= hib_d; ptr_q <= ptr_d;
      word_q <= word_d; oe_q <= oe_d; rw_q <= rw_d; lo_q <= lo_d; hav_q <= hav_d;
      pend_q <= pend_d; mack_q <= mack_d; we_q <= we_d;
      if (we_d) begin
        wa_q <= ptr_q;
        wd_q <= {hib_q, sh_q};
      end
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;

  // R1: bus released whenever the target is idle (unmatched or finished)
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);
  // R2: a word commits only as the low byte's ACK slot closes
  a_r2_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(st_q == ST_WR_ACK));
  // R3: the pointer sits one past the word just committed
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (ptr_q == wa_q + AW'(1)));
  // R4: SDA drive changes only after a falling SCL or a bus condition
  a_r4_sda_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

// File: rtl/i2c_word_bank.sv
module i2c_word_bank #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int RW_BASE = 2,
  parameter int RW_NUM = 4,
  parameter logic [DW-1:0] ID_VAL = 16'h4B54,
  parameter int ID_ADDR = 1,
  parameter int TUNE_ADDR = 3,
  parameter int TUNE_BIT = 15,
  parameter int STAT_ADDR = 18,
  parameter int DONE_BIT = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] status_i,
  input  logic          tune_done_i,
  output logic          tune_start_o
);
  logic [DW-1:0] rw_q [RW_NUM];
  logic done_q, done_d, tune_q, tune_d;
  logic tune_hit;

  for (genvar i = 0; i < RW_NUM; i++) begin : g_rw
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(RW_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rw_q[i] <= '0;
      else if (sel) rw_q[i] <= wr_data;
    end
  end

  assign tune_hit = wr_en && (wr_addr == AW'(TUNE_ADDR)) && wr_data[TUNE_BIT];

  always_comb begin
    tune_d = tune_hit;
    done_d = done_q;
    if (tune_done_i) done_d = 1'b1;
    if (tune_hit)    done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      tune_q <= 1'b0;
    end else begin
      done_q <= done_d;
      tune_q <= tune_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ID_ADDR)) rd_data = ID_VAL;
    if (rd_addr == AW'(STAT_ADDR)) begin
      rd_data = status_i;
      rd_data[DONE_BIT] = done_q;
    end
    for (int i = 0; i < RW_NUM; i++)
      if (rd_addr == AW'(RW_BASE + i)) rd_data = rw_q[i];
  end

  assign tune_start_o = tune_q;

  // R8: the tune strobe lasts a single cycle
  a_r8_tune_single: assert property (@(posedge clk) disable iff (!rst_n)
    tune_q |=> !tune_q);
  // R8: the done flag is low whenever the strobe fires
  a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    tune_q |-> !done_q);
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target #(
  parameter logic [6:0] DEV_ADDR = 7'h35,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [DW-1:0] status_i,
  input  logic          tune_done_i,
  output logic          reg_wr_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          tune_start_o
);
  logic [1:0] rst_pipe_q;
  logic core_rst_n;
  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(core_rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_word_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(core_rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_word(rd_word), .rd_addr(rd_addr), .sda_oe(sda_oe_o),
    .wr_en(reg_wr_o), .wr_addr(reg_addr_o), .wr_data(reg_wdata_o)
  );

  i2c_word_bank #(.AW(AW), .DW(DW)) u_bank (
    .clk(clk), .rst_n(core_rst_n), .rd_addr(rd_addr), .rd_data(rd_word),
    .wr_en(reg_wr_o), .wr_addr(reg_addr_o), .wr_data(reg_wdata_o),
    .status_i(status_i), .tune_done_i(tune_done_i), .tune_start_o(tune_start_o)
  );
endmodule

// File: tb/sim_i2c_word_target.sv
module sim_i2c_word_target;
  localparam int H = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr, tune_start, tune_done = 1'b0;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, status = 16'h0000;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0, wr_cnt = 0, tune_cnt = 0;
  logic [7:0] last_wa;
  logic [15:0] last_wd;
  logic [15:0] m [256];
  logic [15:0] wbuf [8];
  logic [15:0] rbuf [8];
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_word_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .status_i(status), .tune_done_i(tune_done), .reg_wr_o(reg_wr),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .tune_start_o(tune_start)
  );

  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
    if (tune_start) tune_cnt++;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1; tick(H); scl_m = 0;
    end
    sda_m = 1; tick(H); scl_m = 1; tick(H/2); ack = ~sda_line; tick(H/2); scl_m = 0;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(H); scl_m = 1; tick(H/2); b = {b[6:0], sda_line}; tick(H/2); scl_m = 0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(H); scl_m = 1; tick(H); scl_m = 0; sda_m = 1;
  endtask

  task automatic wr_regs(input logic [7:0] a, input int n, output logic all_ack);
    logic k;
    all_ack = 1;
    bus_start();
    send_byte(8'h6A, k); all_ack &= k;
    send_byte(a, k); all_ack &= k;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i][15:8], k); all_ack &= k;
      send_byte(wbuf[i][7:0], k); all_ack &= k;
      if (a + i >= 2 && a + i <= 5) m[a + i] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic rd_body(input int n);
    logic [7:0] hi, lo;
    for (int i = 0; i < n; i++) begin
      recv_byte(1'b1, hi);
      recv_byte(i < n - 1, lo);
      rbuf[i] = {hi, lo};
    end
    bus_stop();
  endtask

  task automatic rd_regs(input logic [7:0] a, input int n, output logic all_ack);
    logic k;
    all_ack = 1;
    bus_start();
    send_byte(8'h6A, k); all_ack &= k;
    send_byte(a, k); all_ack &= k;
    bus_start();
    send_byte(8'h6B, k); all_ack &= k;
    rd_body(n);
  endtask

  function automatic logic [15:0] expect_reg(logic [7:0] a);
    logic [15:0] s;
    if (a == 8'h01) return 16'h4B54;
    if (a >= 2 && a <= 5) return m[a];
    return 16'h0000;
  endfunction

  initial begin
    tick(190000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok, k;
    logic [7:0] b;
    int w0, t0;
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h5A3C;
    for (int i = 0; i < 256; i++) m[i] = 16'h0000;
    tick(5); rst_n = 1; tick(5);

    // R10: reset state
    chk("R10 sda released", sda_oe, 0);
    chk("R10 no strobes", {reg_wr, tune_start}, 0);

    // R5 / R1 / R4: identity register through repeated start
    rd_regs(8'h01, 1, ok);
    chk("R1 ack 6A/6B", ok, 1);
    chk("R5 R4 id read", rbuf[0], 16'h4B54);

    // R8: done flag set by host, cleared by tune write
    rd_regs(8'h12, 1, ok);
    chk("R8 flag reset low", rbuf[0], 16'h0000);
    tune_done = 1; tick(1); tune_done = 0; tick(2);
    rd_regs(8'h12, 1, ok);
    chk("R8 flag set", rbuf[0], 16'h4000);
    t0 = tune_cnt;
    wbuf[0] = 16'h8123; wr_regs(8'h03, 1, ok);
    chk("R8 one pulse", tune_cnt - t0, 1);
    rd_regs(8'h12, 1, ok);
    chk("R8 flag cleared", rbuf[0], 16'h0000);
    t0 = tune_cnt;
    wbuf[0] = 16'h0123; wr_regs(8'h03, 1, ok);
    chk("R8 no pulse bit15 clear", tune_cnt - t0, 0);

    // R9: host status passthrough
    status = 16'hFFFF;
    rd_regs(8'h12, 1, ok);
    chk("R9 status all ones", rbuf[0], 16'hBFFF);
    status = 16'h4001;
    rd_regs(8'h12, 1, ok);
    chk("R9 status bit14 masked", rbuf[0], 16'h0001);
    status = 16'h0000;

    // R2 R11 R7: sweep writable registers with several patterns
    for (int a = 2; a <= 5; a++) begin
      for (int p = 0; p < 4; p++) begin
        w0 = wr_cnt;
        wbuf[0] = pats[p] ^ 16'(a * 16'h0111);
        wr_regs(8'(a), 1, ok);
        chk("R2 write acked", ok, 1);
        chk("R11 strobe once", wr_cnt - w0, 1);
        chk("R11 strobe addr/data", {last_wa, last_wd}, {8'(a), wbuf[0]});
        rd_regs(8'(a), 1, ok);
        chk("R2 R7 readback", rbuf[0], expect_reg(8'(a)));
      end
    end

    // R3: burst write then burst read across registers
    wbuf[0] = 16'h1357; wbuf[1] = 16'h2468; wbuf[2] = 16'hBEEF;
    wr_regs(8'h02, 3, ok);
    rd_regs(8'h01, 5, ok);
    for (int i = 0; i < 5; i++)
      chk("R3 burst read", rbuf[i], expect_reg(8'(1 + i)));

    // R3: pointer continues after a full read word
    rd_regs(8'h03, 1, ok);
    bus_start(); send_byte(8'h6B, k); rd_body(1);
    chk("R3 continue at next", rbuf[0], expect_reg(8'h04));

    // R5 R7: writes to identity and unimplemented registers are ignored
    wbuf[0] = 16'h0000; wr_regs(8'h01, 1, ok);
    wbuf[0] = 16'hFACE; wr_regs(8'h40, 1, ok);
    rd_regs(8'h01, 1, ok);
    chk("R5 id unchanged", rbuf[0], 16'h4B54);
    rd_regs(8'h40, 1, ok);
    chk("R7 unimplemented zero", rbuf[0], 16'h0000);

    // R6: lone high byte discarded
    wbuf[0] = 16'h1111; wr_regs(8'h04, 1, ok);
    w0 = wr_cnt;
    bus_start(); send_byte(8'h6A, k); send_byte(8'h04, k); send_byte(8'h22, k); bus_stop();
    chk("R6 no strobe", wr_cnt - w0, 0);
    rd_regs(8'h04, 1, ok);
    chk("R6 reg kept", rbuf[0], 16'h1111);

    // R1: foreign address NACKed and later bytes ignored
    bus_start();
    send_byte(8'h50, k); chk("R1 nack foreign", k, 0);
    send_byte(8'h6A, k); chk("R1 ignored till start", k, 0);
    bus_stop();
    bus_start(); send_byte(8'h6B ^ 8'h80, k); chk("R1 nack foreign read", k, 0); bus_stop();
    rd_regs(8'h04, 1, ok);
    chk("R1 recovers after start", {ok, rbuf[0]}, {1'b1, 16'h1111});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule